// File: doc/BRIEF.md
# Stop-Clock Power State Controller

This controller places the core of a processor-like agent into a low-power stop-grant state and brings it back out again. System logic asserts the stop request at any time, with no relation to the local clock. The block brings that request into the clock domain through a two-flop synchronizer. It acts on a new level only after the synchronized value has held for two consecutive samples, so a one-cycle glitch is filtered out.

On an accepted request the controller raises an acknowledge request toward the bus interface and waits for the acknowledge-done handshake. Only then does it remove the clock enables of the core domains. The bus-interface domain and the interrupt-controller domain keep their enables in every state, so snooping and interrupt service continue while the core is stopped. The bus clock itself is never touched.

When the request is removed, the controller restores all core enables in a resume phase of a parameterised length and then returns to normal running. If the request disappears while the acknowledge is still outstanding, the acknowledge is completed and the controller returns straight to running without gating anything. The block only produces enables; the gating cells in the clock tree lie outside it.

Top module: `stopclk_ctrl`

## Requirements
- R1: During and immediately after reset, the state indicator reads RUN (code 0), every bit of the domain enable vector is 1 and the acknowledge request is 0.
- R2: A level change on the asynchronous stop request, applied between clock edges, is acted on at the fifth rising edge after it: the state still holds its old value after four edges and changes on the fifth.
- R3: A stop request pulse lasting a single clock cycle is ignored, and the state stays RUN.
- R4: In the acknowledge-pending state (code 1), the acknowledge request is 1 and every domain enable stays 1. The state holds until acknowledge-done is sampled high.
- R5: When acknowledge-done is sampled high in the acknowledge-pending state while the qualified request is still present, the next state is stop-grant (code 2). On that same edge the core-domain enables (bits NUM_AON and above) drop to 0 and the acknowledge request drops to 0.
- R6: The always-on enables, bit 0 (bus interface) and bit 1 (interrupt controller) with the default NUM_AON of 2, are 1 in every state.
- R7: When the qualified request is removed in stop-grant, the state moves to resume (code 3) with all enables back to 1. It stays there for RESUME_CYCLES cycles (default 2) and then returns to RUN.
- R8: If the request is withdrawn while acknowledge-pending, the state holds until acknowledge-done arrives and then goes directly to RUN. The core enables never drop during this sequence.
- R9: Acknowledge-done has no effect outside the acknowledge-pending state: in RUN the state stays RUN with the acknowledge request at 0, and in stop-grant the state and the enables stay unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running block clock |
| rst | input | 1 | Synchronous active-high reset |
| stop_req_i | input | 1 | Asynchronous stop-clock request, active high |
| ack_done_i | input | 1 | Acknowledge transaction completed |
| dom_en_o | output | NUM_DOM | Per-domain clock enables: always-on domains in the low bits, core domains above |
| ack_req_o | output | 1 | Request to issue the stop-grant acknowledge transaction |
| state_o | output | 2 | Power state: 0 RUN, 1 acknowledge-pending, 2 stop-grant, 3 resume |

## Verification
The hardest situation to reach from the ports is a request that is withdrawn while the acknowledge is still outstanding. The stimulus raises the request, waits until acknowledge-pending is visible, and then drops the request. It holds acknowledge-done low long enough for the synchronizer and qualifier to see the drop before completing the handshake, and then checks that the state returns directly to RUN with no cycle of gating. The single-cycle glitch case is also driven deliberately, with the request held high across exactly one rising edge.

// File: rtl/stopclk_pkg.sv
package stopclk_pkg;

    typedef enum logic [1:0] {
        PS_RUN     = 2'd0,
        PS_ACK     = 2'd1,
        PS_GRANT   = 2'd2,
        PS_RESUME  = 2'd3
    } pwr_state_e;

    typedef struct packed {
        pwr_state_e state;
        logic       ack_req;
        logic       gate_core;
    } pwr_ctl_t;

    function automatic logic core_gated(input pwr_state_e s);
        return (s == PS_GRANT);
    endfunction

    function automatic logic ack_active(input pwr_state_e s);
        return (s == PS_ACK);
    endfunction

endpackage

// File: rtl/stopclk_sync.sv
module stopclk_sync #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic async_i,
    output logic qual_o
);
    localparam int LAST = SYNC_STAGES - 1;

    logic [SYNC_STAGES-1:0] chain_q;
    logic                   hist_q;
    logic                   qual_q;

    genvar g;
    generate
        for (g = 0; g < SYNC_STAGES; g++) begin : g_stage
            if (g == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (rst) chain_q[g] <= 1'b0;
                    else     chain_q[g] <= async_i;
                end
            end else begin : g_rest
                always_ff @(posedge clk) begin
                    if (rst) chain_q[g] <= 1'b0;
                    else     chain_q[g] <= chain_q[g-1];
                end
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) begin
            hist_q <= 1'b0;
            qual_q <= 1'b0;
        end else begin
            hist_q <= chain_q[LAST];
            if (chain_q[LAST] == hist_q)
                qual_q <= hist_q;
        end
    end

    assign qual_o = qual_q;

endmodule

// File: rtl/stopclk_fsm.sv
module stopclk_fsm
    import stopclk_pkg::*;
#(
    parameter int RESUME_CYCLES = 2
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     req_i,
    input  logic     ack_done_i,
    output pwr_ctl_t ctl_o
);
    localparam int CNT_W = (RESUME_CYCLES > 1) ? $clog2(RESUME_CYCLES) : 1;
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(RESUME_CYCLES - 1);

    pwr_state_e       state_q, state_d;
    logic [CNT_W-1:0] cnt_q;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            PS_RUN: begin
                if (req_i) state_d = PS_ACK;
            end
            PS_ACK: begin
                if (ack_done_i) state_d = req_i ? PS_GRANT : PS_RUN;
            end
            PS_GRANT: begin
                if (!req_i) state_d = PS_RESUME;
            end
            PS_RESUME: begin
                if (cnt_q == CNT_LAST) state_d = PS_RUN;
            end
            default: state_d = PS_RUN;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= PS_RUN;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            if (state_q == PS_RESUME) cnt_q <= cnt_q + 1'b1;
            else                      cnt_q <= '0;
        end
    end

    always_comb begin
        ctl_o.state     = state_q;
        ctl_o.ack_req   = ack_active(state_q);
        ctl_o.gate_core = core_gated(state_q);
    end

endmodule

// File: rtl/stopclk_en_gen.sv
module stopclk_en_gen #(
    parameter int NUM_DOM = 6,
    parameter int NUM_AON = 2
) (
    input  logic               gate_core_i,
    output logic [NUM_DOM-1:0] en_o
);
    genvar d;
    generate
        for (d = 0; d < NUM_DOM; d++) begin : g_dom
            if (d < NUM_AON) begin : g_aon
                assign en_o[d] = 1'b1;
            end else begin : g_core
                assign en_o[d] = ~gate_core_i;
            end
        end
    endgenerate
endmodule

// File: rtl/stopclk_ctrl.sv
module stopclk_ctrl
    import stopclk_pkg::*;
#(
    parameter int NUM_CORE      = 4,
    parameter int NUM_AON       = 2,
    parameter int SYNC_STAGES   = 2,
    parameter int RESUME_CYCLES = 2,
    localparam int NUM_DOM      = NUM_CORE + NUM_AON
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               stop_req_i,
    input  logic               ack_done_i,
    output logic [NUM_DOM-1:0] dom_en_o,
    output logic               ack_req_o,
    output logic [1:0]         state_o
);
    logic     req_qual;
    pwr_ctl_t ctl;

    stopclk_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst     (rst),
        .async_i (stop_req_i),
        .qual_o  (req_qual)
    );

    stopclk_fsm #(.RESUME_CYCLES(RESUME_CYCLES)) u_fsm (
        .clk        (clk),
        .rst        (rst),
        .req_i      (req_qual),
        .ack_done_i (ack_done_i),
        .ctl_o      (ctl)
    );

    stopclk_en_gen #(.NUM_DOM(NUM_DOM), .NUM_AON(NUM_AON)) u_en (
        .gate_core_i (ctl.gate_core),
        .en_o        (dom_en_o)
    );

    assign ack_req_o = ctl.ack_req;
    assign state_o   = ctl.state;

endmodule

// File: rtl/stopclk_ctrl_chk.sv
module stopclk_ctrl_chk #(
    parameter int NUM_DOM = 6,
    parameter int NUM_AON = 2
) (
    input logic               clk,
    input logic               rst,
    input logic               ack_done_i,
    input logic [NUM_DOM-1:0] dom_en_o,
    input logic               ack_req_o,
    input logic [1:0]         state_o
);
    localparam logic [NUM_AON-1:0] AON_ONES = '1;
    localparam logic [NUM_DOM-NUM_AON-1:0] CORE_ONES = '1;

    assert_aon_on_R6: assert property (@(posedge clk) disable iff (rst)
        dom_en_o[NUM_AON-1:0] == AON_ONES);

    assert_ack_hold_R4: assert property (@(posedge clk) disable iff (rst)
        (ack_req_o && !ack_done_i) |=> (ack_req_o && state_o == 2'd1));

    assert_ack_all_on_R4: assert property (@(posedge clk) disable iff (rst)
        ack_req_o |-> dom_en_o[NUM_DOM-1:NUM_AON] == CORE_ONES);

    assert_grant_after_ack_R5: assert property (@(posedge clk) disable iff (rst)
        (state_o == 2'd2 && $past(state_o) != 2'd2) |-> $past(ack_done_i && ack_req_o));

    assert_grant_gated_R5: assert property (@(posedge clk) disable iff (rst)
        (state_o == 2'd2) |-> (dom_en_o[NUM_DOM-1:NUM_AON] == '0 && !ack_req_o));

    assert_resume_on_R7: assert property (@(posedge clk) disable iff (rst)
        (state_o == 2'd3) |-> dom_en_o[NUM_DOM-1:NUM_AON] == CORE_ONES);

    assert_ack_exit_R8: assert property (@(posedge clk) disable iff (rst)
        (ack_req_o && ack_done_i) |=> (state_o == 2'd0 || state_o == 2'd2));

    assert_run_ignores_done_R9: assert property (@(posedge clk) disable iff (rst)
        (state_o == 2'd0) |=> (state_o == 2'd0 || state_o == 2'd1));

endmodule

bind stopclk_ctrl stopclk_ctrl_chk #(.NUM_DOM(NUM_DOM), .NUM_AON(NUM_AON)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .ack_done_i (ack_done_i),
    .dom_en_o   (dom_en_o),
    .ack_req_o  (ack_req_o),
    .state_o    (state_o)
);

// File: tb/stopclk_ctrl_tb.sv
`timescale 1ns/1ps
module stopclk_ctrl_tb;
    localparam int ALL_ON = 63;
    localparam int GATED  = 3;
    localparam int S_RUN = 0, S_ACK = 1, S_GRANT = 2, S_RES = 3;

    logic       clk = 1'b0;
    logic       rst;
    logic       stop_req;
    logic       ack_done;
    logic [5:0] dom_en;
    logic       ack_req;
    logic [1:0] state;

    int checks = 0;
    int failures = 0;

    always #4 clk = ~clk;

    stopclk_ctrl u_dut (
        .clk        (clk),
        .rst        (rst),
        .stop_req_i (stop_req),
        .ack_done_i (ack_done),
        .dom_en_o   (dom_en),
        .ack_req_o  (ack_req),
        .state_o    (state)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        for (int i = 0; i < n; i++) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic t_reset;
        rst = 1'b1; stop_req = 1'b0; ack_done = 1'b0;
        cyc(3);
        chk("R1 state in reset", int'(state), S_RUN);
        rst = 1'b0;
        cyc(1);
        chk("R1 state", int'(state), S_RUN);
        chk("R1 enables", int'(dom_en), ALL_ON);
        chk("R1 ack_req", int'(ack_req), 0);
    endtask

    task automatic t_glitch;
        stop_req = 1'b1;
        cyc(1);
        stop_req = 1'b0;
        for (int i = 0; i < 10; i++) begin
            chk("R3 glitch state", int'(state), S_RUN);
            cyc(1);
        end
    endtask

    task automatic t_done_in_run;
        ack_done = 1'b1;
        for (int i = 0; i < 3; i++) begin
            cyc(1);
            chk("R9 run state", int'(state), S_RUN);
            chk("R9 run ack_req", int'(ack_req), 0);
        end
        ack_done = 1'b0;
        cyc(1);
    endtask

    task automatic t_enter;
        stop_req = 1'b1;
        cyc(4);
        chk("R2 rise after 4 edges", int'(state), S_RUN);
        cyc(1);
        chk("R2 rise after 5 edges", int'(state), S_ACK);
        chk("R4 ack_req", int'(ack_req), 1);
        chk("R4 enables", int'(dom_en), ALL_ON);
        cyc(3);
        chk("R4 holds without done", int'(state), S_ACK);
        ack_done = 1'b1;
        cyc(1);
        ack_done = 1'b0;
        chk("R5 state", int'(state), S_GRANT);
        chk("R5 enables", int'(dom_en), GATED);
        chk("R5 ack_req", int'(ack_req), 0);
        chk("R6 always-on bits", int'(dom_en[1:0]), 3);
    endtask

    task automatic t_done_in_grant;
        ack_done = 1'b1;
        cyc(1);
        ack_done = 1'b0;
        cyc(1);
        chk("R9 grant state", int'(state), S_GRANT);
        chk("R9 grant enables", int'(dom_en), GATED);
    endtask

    task automatic t_resume;
        stop_req = 1'b0;
        cyc(4);
        chk("R2 fall after 4 edges", int'(state), S_GRANT);
        cyc(1);
        chk("R7 resume state", int'(state), S_RES);
        chk("R7 resume enables", int'(dom_en), ALL_ON);
        cyc(1);
        chk("R7 resume second cycle", int'(state), S_RES);
        cyc(1);
        chk("R7 back to run", int'(state), S_RUN);
        chk("R7 run enables", int'(dom_en), ALL_ON);
    endtask

    task automatic t_withdraw;
        stop_req = 1'b1;
        cyc(5);
        chk("R8 entered ack", int'(state), S_ACK);
        stop_req = 1'b0;
        for (int i = 0; i < 8; i++) begin
            cyc(1);
            chk("R8 waits for done", int'(state), S_ACK);
            chk("R8 enables on", int'(dom_en), ALL_ON);
        end
        ack_done = 1'b1;
        cyc(1);
        ack_done = 1'b0;
        chk("R8 direct to run", int'(state), S_RUN);
        chk("R8 enables after", int'(dom_en), ALL_ON);
        cyc(5);
        chk("R8 stays run", int'(state), S_RUN);
    endtask

    initial begin
        t_reset();
        t_glitch();
        t_done_in_run();
        t_enter();
        t_done_in_grant();
        t_resume();
        t_withdraw();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        failures++;
        $display("FAIL watchdog actual=timeout expected=completion");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule